// File: doc/BRIEF.md
# Two-Wire Bus Master Controller with Bus-Idle Interrupt

This block is a register-mapped master for a two-wire serial bus with one clock line and one data line. Both lines are open-drain. The block never drives a line high. It either pulls a line low through an output-enable pin or releases it, and it reads the wired-AND level back through an input pin. Software sets a master-select bit to claim the bus, which produces a START condition. The first byte written to the data register after that is sent as the address byte. Each later data write moves one byte, in the direction chosen in the control register. Clearing master-select between bytes produces a STOP condition.

The bus-busy flag is taken from START and STOP conditions seen on the synchronised lines, so it also follows traffic from any other device. One interrupt flag collects two events. The first is the end of each byte, after the ninth clock. The second, when software enables it, is the falling edge of bus-busy, which marks a finished STOP. The enable for the bus-idle event only takes a 1 while the block holds master-select. Each clock phase lasts a fixed number of system-clock cycles set by a parameter.

Register map. The address is on `regAddr`, and unused addresses read 0.
- 0x0 control: bit 7 global interrupt enable, bit 6 master select, bit 5 transmit mode (1 = transmit, 0 = receive), bit 4 withhold acknowledge on receive.
- 0x1 status: bit 7 no byte in flight, bit 5 bus busy, bit 1 interrupt flag (write 1 to clear), bit 0 acknowledge sampled (1 = not acknowledged).
- 0x2 data.
- 0x5 idle-config: bit 7 bus-idle interrupt enable.

Top module: `iic_master`

## Requirements
- R1: After reset, control reads 0x00, status reads 0x80, data reads 0x00 and idle-config reads 0x00. Both output enables are 0 and `irq` is 0.
- R2: The lines are only ever pulled low or released, and both are released while idle. SDA changes while SCL is high only to form a START or a STOP, so a receiver sees exactly one START and one STOP per transfer.
- R3: Status bit 5 (bus busy) goes to 1 after SDA falls while SCL is high, and goes to 0 after SDA rises while SCL is high. Both lines are synchronised before edge detection.
- R4: Writing control bit 6 to 1 while the bus is free generates a START. The next data write is sent as the address byte, MSB first: bits 7..1 are the target address and bit 0 is the direction (1 = read).
- R5: The acknowledge bit is sampled while SCL is high during the ninth clock. Status bit 0 reads 1 when the target did not acknowledge and 0 when it did.
- R6: With control bit 5 = 1, a data write sends that byte MSB first. With control bit 5 = 0, a data write starts a one-byte receive. The master drives an acknowledge unless control bit 4 = 1. A data read returns the last received byte and never the byte written for transmit.
- R7: Idle-config bit 7 is the bus-idle interrupt enable, and its bits 6..0 read 0. A write of 1 to bit 7 takes effect only while control bit 6 = 1; otherwise the bit stays 0.
- R8: Status bit 1 is set after the ninth clock of every byte and is cleared by writing 1 to it. The `irq` output equals status bit 1 AND control bit 7.
- R9: When idle-config bit 7 = 1, a 1-to-0 change of bus busy sets status bit 1. When it is 0, the end of a STOP leaves status bit 1 unchanged.
- R10: Clearing control bit 6 while the block holds the bus between bytes generates a STOP. Status bit 7 reads 1 whenever no byte is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| sclIn | input | 1 | Level sensed on the clock line |
| sdaIn | input | 1 | Level sensed on the data line |
| sclOe | output | 1 | 1 pulls the clock line low |
| sdaOe | output | 1 | 1 pulls the data line low |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a quarter-period of 5 system clocks and the default two-stage synchroniser. This gives a byte of about 180 cycles, so several write, read and rejected-address transfers fit in a short run. A behavioural target on the wired-AND lines acknowledges one address, stores written bytes, returns computed bytes and counts START and STOP conditions. Together these make the address phase, the acknowledge sampling in both directions, the bus-idle interrupt and the master-only rule for its enable all observable at the ports.

// File: rtl/iic_pkg.sv
package iic_pkg;

  localparam int BYTE_W = 8;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_DATA = 3'd2;
  localparam logic [2:0] REG_ICFG = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic              loadShift;
    logic [BYTE_W-1:0] loadVal;
    logic              sampleBit;
    logic              sampleAck;
    logic              captureRx;
    logic              tickRestart;
  } dpCmd_t;

  // observations from datapath back to control
  typedef struct packed {
    logic              tick;
    logic              shiftMsb;
    logic [BYTE_W-1:0] rxData;
    logic              ackIn;
    logic              busy;
    logic              busyFell;
  } dpStat_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_BIT, ST_STOPA, ST_STOPB, ST_STOPC
  } ctlState_t;

endpackage

// File: rtl/iic_datapath.sv
module iic_datapath
  import iic_pkg::*;
#(
  parameter int QUARTER     = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  dpCmd_t  cmd,
  output dpStat_t stat
);

  localparam int CNT_W = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUARTER - 1);

  // line synchronisers, one stage per generate step
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[gi] <= 1'b1;
          sdaPipe[gi] <= 1'b1;
        end else if (gi == 0) begin
          sclPipe[gi] <= sclIn;
          sdaPipe[gi] <= sdaIn;
        end else begin
          sclPipe[gi] <= sclPipe[(gi > 0) ? gi - 1 : 0];
          sdaPipe[gi] <= sdaPipe[(gi > 0) ? gi - 1 : 0];
        end
      end
    end
  endgenerate

  logic sclSync, sdaSync, sclDly, sdaDly;
  assign sclSync = sclPipe[SYNC_STAGES-1];
  assign sdaSync = sdaPipe[SYNC_STAGES-1];

  logic startDet, stopDet;
  assign startDet = sclSync && sclDly && sdaDly && !sdaSync;
  assign stopDet  = sclSync && sclDly && !sdaDly && sdaSync;

  logic busyQ, busyDly;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclDly  <= 1'b1;
      sdaDly  <= 1'b1;
      busyQ   <= 1'b0;
      busyDly <= 1'b0;
    end else begin
      sclDly  <= sclSync;
      sdaDly  <= sdaSync;
      busyDly <= busyQ;
      if (startDet)     busyQ <= 1'b1;
      else if (stopDet) busyQ <= 1'b0;
    end
  end

  // quarter-period timebase
  logic [CNT_W-1:0] tickCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   tickCnt <= '0;
    else if (cmd.tickRestart)    tickCnt <= '0;
    else if (tickCnt == CNT_LAST) tickCnt <= '0;
    else                          tickCnt <= tickCnt + 1'b1;
  end

  // shared shift register: transmit MSB out, sampled line shifted in
  logic [BYTE_W-1:0] shiftQ, rxQ;
  logic              ackQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      rxQ    <= '0;
      ackQ   <= 1'b0;
    end else begin
      if (cmd.loadShift)      shiftQ <= cmd.loadVal;
      else if (cmd.sampleBit) shiftQ <= {shiftQ[BYTE_W-2:0], sdaSync};
      if (cmd.captureRx)      rxQ    <= shiftQ;
      if (cmd.sampleAck)      ackQ   <= sdaSync;
    end
  end

  assign stat.tick     = (tickCnt == CNT_LAST) && !cmd.tickRestart;
  assign stat.shiftMsb = shiftQ[BYTE_W-1];
  assign stat.rxData   = rxQ;
  assign stat.ackIn    = ackQ;
  assign stat.busy     = busyQ;
  assign stat.busyFell = busyDly && !busyQ;

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> busyQ) else $error("busy not set after START"); // R3
  AST_BUSY_OFF_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !busyQ) else $error("busy not cleared after STOP"); // R3

endmodule

// File: rtl/iic_ctrl.sv
module iic_ctrl
  import iic_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  dpStat_t     stat,
  output dpCmd_t      cmd,
  output logic        sclLow,
  output logic        sdaLow,
  output logic        irq
);

  localparam logic [3:0] ACK_IDX = 4'(BYTE_W);

  logic gieQ, mselQ, txQ, nakQ, idleIeQ, irqFlagQ, doneQ;
  logic isRxQ, addrPendQ;
  logic [1:0] phaseQ;
  logic [3:0] bitIdxQ;
  ctlState_t stateQ;

  logic wrCtrl, wrStat, wrData, wrIcfg;
  assign wrCtrl = regWr && (regAddr == REG_CTRL);
  assign wrStat = regWr && (regAddr == REG_STAT);
  assign wrData = regWr && (regAddr == REG_DATA);
  assign wrIcfg = regWr && (regAddr == REG_ICFG);

  logic startGo, loadGo, stopGo, byteEnd, idleEvt;
  assign startGo = (stateQ == ST_IDLE) && mselQ && !stat.busy;
  assign loadGo  = (stateQ == ST_HOLD) && wrData;
  assign stopGo  = (stateQ == ST_HOLD) && !mselQ && !wrData;
  assign byteEnd = (stateQ == ST_BIT) && stat.tick && (phaseQ == 2'd3) && (bitIdxQ == ACK_IDX);
  assign idleEvt = idleIeQ && stat.busyFell;

  always_comb begin
    cmd.tickRestart = startGo || loadGo || stopGo;
    cmd.loadShift   = loadGo;
    cmd.loadVal     = (addrPendQ || txQ) ? regWrData : '1;
    cmd.sampleBit   = (stateQ == ST_BIT) && stat.tick && (phaseQ == 2'd2) && (bitIdxQ != ACK_IDX);
    cmd.sampleAck   = (stateQ == ST_BIT) && stat.tick && (phaseQ == 2'd2) && (bitIdxQ == ACK_IDX);
    cmd.captureRx   = byteEnd && isRxQ;
  end

  // software-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gieQ     <= 1'b0;
      mselQ    <= 1'b0;
      txQ      <= 1'b0;
      nakQ     <= 1'b0;
      idleIeQ  <= 1'b0;
      irqFlagQ <= 1'b0;
    end else begin
      if (wrCtrl) begin
        gieQ  <= regWrData[7];
        mselQ <= regWrData[6];
        txQ   <= regWrData[5];
        nakQ  <= regWrData[4];
      end
      if (wrIcfg) idleIeQ <= regWrData[7] && mselQ;
      if (byteEnd || idleEvt)        irqFlagQ <= 1'b1;
      else if (wrStat && regWrData[1]) irqFlagQ <= 1'b0;
    end
  end

  // bus sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      sclLow    <= 1'b0;
      sdaLow    <= 1'b0;
      phaseQ    <= '0;
      bitIdxQ   <= '0;
      isRxQ     <= 1'b0;
      addrPendQ <= 1'b0;
      doneQ     <= 1'b1;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          sclLow <= 1'b0;
          sdaLow <= 1'b0;
          if (startGo) begin
            sdaLow <= 1'b1;
            phaseQ <= '0;
            stateQ <= ST_START;
          end
        end
        ST_START: if (stat.tick) begin
          if (phaseQ == 2'd1) begin
            sclLow    <= 1'b1;
            addrPendQ <= 1'b1;
            stateQ    <= ST_HOLD;
          end else begin
            phaseQ <= phaseQ + 1'b1;
          end
        end
        ST_HOLD: begin
          if (loadGo) begin
            isRxQ   <= !(addrPendQ || txQ);
            bitIdxQ <= '0;
            phaseQ  <= '0;
            doneQ   <= 1'b0;
            stateQ  <= ST_BIT;
          end else if (stopGo) begin
            sdaLow <= 1'b1;
            stateQ <= ST_STOPA;
          end
        end
        ST_BIT: if (stat.tick) begin
          case (phaseQ)
            2'd0: begin
              if (bitIdxQ == ACK_IDX) sdaLow <= isRxQ && !nakQ;
              else                    sdaLow <= !isRxQ && !stat.shiftMsb;
              phaseQ <= 2'd1;
            end
            2'd1: begin
              sclLow <= 1'b0;
              phaseQ <= 2'd2;
            end
            2'd2: phaseQ <= 2'd3;
            default: begin
              sclLow <= 1'b1;
              phaseQ <= 2'd0;
              if (bitIdxQ == ACK_IDX) begin
                doneQ     <= 1'b1;
                addrPendQ <= 1'b0;
                stateQ    <= ST_HOLD;
              end else begin
                bitIdxQ <= bitIdxQ + 1'b1;
              end
            end
          endcase
        end
        ST_STOPA: if (stat.tick) begin
          sclLow <= 1'b0;
          stateQ <= ST_STOPB;
        end
        ST_STOPB: if (stat.tick) begin
          sdaLow <= 1'b0;
          stateQ <= ST_STOPC;
        end
        ST_STOPC: if (stat.tick) stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      REG_CTRL: regRdData = {gieQ, mselQ, txQ, nakQ, 4'b0};
      REG_STAT: regRdData = {doneQ, 1'b0, stat.busy, 3'b0, irqFlagQ, stat.ackIn};
      REG_DATA: regRdData = stat.rxData;
      REG_ICFG: regRdData = {idleIeQ, 7'b0};
      default:  regRdData = 8'h00;
    endcase
  end

  assign irq = irqFlagQ && gieQ;

  AST_IDLE_EN_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleIeQ) |-> $past(mselQ)) else $error("idle enable set outside master"); // R7
  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_BIT && !sclLow && $past(!sclLow)) |-> $stable(sdaLow))
    else $error("SDA moved while SCL high"); // R2
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlagQ) |-> ($past(stat.busyFell) || $past(stateQ == ST_BIT && phaseQ == 2'd3)))
    else $error("interrupt flag without event"); // R8
  AST_SCL_HELD_BETWEEN_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD) |-> sclLow) else $error("SCL released between bytes"); // R10

endmodule

// File: rtl/iic_master.sv
module iic_master
  import iic_pkg::*;
#(
  parameter int QUARTER     = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regWr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       irq
);

  dpCmd_t  dpCmd;
  dpStat_t dpStat;

  iic_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .stat      (dpStat),
    .cmd       (dpCmd),
    .sclLow    (sclOe),
    .sdaLow    (sdaOe),
    .irq       (irq)
  );

  iic_datapath #(.QUARTER(QUARTER), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .cmd   (dpCmd),
    .stat  (dpStat)
  );

endmodule

// File: tb/test_iic_master.sv
module test_iic_master;

  localparam int         QUARTER  = 5;
  localparam logic [6:0] SLV_ADDR = 7'h52;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [2:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic [7:0] regWrData = '0;
  wire  [7:0] regRdData;
  wire        sclOe, sdaOe, irq;
  logic       slvSdaLow = 1'b0;

  wire sclLine = ~sclOe;
  wire sdaLine = ~(sdaOe | slvSdaLow);

  iic_master #(.QUARTER(QUARTER)) i_iic_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe), .irq(irq)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rspByte(input int idx);
    return 8'hC3 ^ 8'(idx * 37);
  endfunction

  // behavioural target on the wired-AND lines
  int         slvStarts = 0, slvStops = 0, slvRxN = 0, slvTxIdx = 0;
  logic [3:0] slvCnt = '0;
  logic       slvAddrPh = 1'b0, slvMatch = 1'b0, slvRead = 1'b0, slvMAck = 1'b0, slvSend = 1'b0;
  logic [7:0] slvShift = '0, slvTx = '0;
  logic [7:0] slvMem [16];

  always @(negedge sdaLine) if (sclLine === 1'b1 && rstN) begin
    slvStarts++;
    slvCnt = 0; slvAddrPh = 1'b1; slvMatch = 1'b0; slvRead = 1'b0; slvSend = 1'b0;
  end

  always @(posedge sdaLine) if (sclLine === 1'b1 && rstN) begin
    slvStops++;
    slvAddrPh = 1'b0; slvMatch = 1'b0; slvSend = 1'b0;
  end

  always @(posedge sclLine) if (rstN) begin
    if (slvCnt < 8) slvShift = {slvShift[6:0], sdaLine};
    else if (slvRead) slvMAck = ~sdaLine;
    slvCnt = slvCnt + 1;
  end

  always @(negedge sclLine) if (rstN) begin
    if (slvCnt == 8) begin
      if (slvAddrPh) begin
        slvMatch  = (slvShift[7:1] == SLV_ADDR);
        slvRead   = slvShift[0];
        slvSdaLow = slvMatch;
      end else if (slvMatch && !slvRead) begin
        slvMem[slvRxN % 16] = slvShift;
        slvRxN++;
        slvSdaLow = 1'b1;
      end else begin
        slvSdaLow = 1'b0;
      end
    end else if (slvCnt == 9) begin
      slvCnt    = 0;
      slvSdaLow = 1'b0;
      if (slvMatch && slvRead && (slvAddrPh || slvMAck)) begin
        if (!slvAddrPh) slvTxIdx++;
        slvTx     = rspByte(slvTxIdx);
        slvSend   = 1'b1;
        slvSdaLow = ~slvTx[7];
      end else begin
        slvSend = 1'b0;
      end
      slvAddrPh = 1'b0;
    end else if (slvCnt >= 1 && slvCnt <= 7 && slvSend) begin
      slvSdaLow = ~slvTx[7 - slvCnt];
    end
  end

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitStat(input logic [7:0] mask, input logic [7:0] val, input string req);
    logic [7:0] s;
    for (int i = 0; i < 5000; i++) begin
      rdReg(3'd1, s);
      if ((s & mask) == val) return;
    end
    check({req, " wait timeout"}, s & mask, val);
  endtask

  task automatic xferByte(input logic [7:0] d);
    wrReg(3'd2, d);
    waitStat(8'h02, 8'h02, "R8");
  endtask

  logic [7:0] rv;
  int startBase, stopBase;

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (5) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    startBase = slvStarts; stopBase = slvStops;

    // R1 reset state
    rdReg(3'd0, rv); check("R1 ctrl", rv, 8'h00);
    rdReg(3'd1, rv); check("R1 stat", rv, 8'h80);
    rdReg(3'd2, rv); check("R1 data", rv, 8'h00);
    rdReg(3'd5, rv); check("R1 icfg", rv, 8'h00);
    check("R1 lines/irq", {sclOe, sdaOe, irq}, 3'b000);

    // R7 enable refused outside master
    wrReg(3'd5, 8'h80);
    rdReg(3'd5, rv); check("R7 refused when not master", rv, 8'h00);

    // write transfer
    wrReg(3'd0, 8'hE0);
    waitStat(8'h20, 8'h20, "R3");
    rdReg(3'd1, rv); check("R3 busy after START", rv[5], 1'b1);
    check("R4 START seen", slvStarts - startBase, 1);
    repeat (4 * QUARTER) @(posedge clk);
    wrReg(3'd5, 8'hFF);
    rdReg(3'd5, rv); check("R7 accepted as master", rv, 8'h80);

    xferByte({SLV_ADDR, 1'b0});
    @(negedge clk);
    check("R8 irq pin", irq, 1'b1);
    rdReg(3'd1, rv); check("R5 address acked", rv[0], 1'b0);
    check("R10 done after byte", rv[7], 1'b1);
    wrReg(3'd1, 8'h02);
    rdReg(3'd1, rv); check("R8 flag cleared", rv[1], 1'b0);
    check("R8 irq pin cleared", irq, 1'b0);

    for (int i = 0; i < 5; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      xferByte(d);
      wrReg(3'd1, 8'h02);
      check("R6 target got byte", slvMem[i], d);
      rdReg(3'd1, rv); check("R5 data acked", rv[0], 1'b0);
      rdReg(3'd2, rv); check("R6 data not echoed", rv, 8'h00);
    end

    wrReg(3'd0, 8'h80);
    waitStat(8'h20, 8'h00, "R10");
    repeat (4) @(posedge clk);
    rdReg(3'd1, rv);
    check("R9 idle sets flag", rv[1], 1'b1);
    check("R10 status idle", rv[7], 1'b1);
    check("R10 STOP seen", slvStops - stopBase, 1);
    check("R2 lines released", {sclOe, sdaOe}, 2'b00);
    wrReg(3'd1, 8'h02);

    // read transfer
    wrReg(3'd0, 8'hE0);
    waitStat(8'h20, 8'h20, "R4");
    repeat (4 * QUARTER) @(posedge clk);
    xferByte({SLV_ADDR, 1'b1});
    wrReg(3'd1, 8'h02);
    rdReg(3'd1, rv); check("R5 read address acked", rv[0], 1'b0);
    for (int i = 0; i < 3; i++) begin
      wrReg(3'd0, (i == 2) ? 8'hD0 : 8'hC0);
      xferByte(8'h5A);
      wrReg(3'd1, 8'h02);
      rdReg(3'd2, rv); check("R6 received byte", rv, rspByte(i));
      check("R6 master ack behaviour", slvMAck, (i == 2) ? 1'b0 : 1'b1);
    end
    wrReg(3'd0, 8'h80);
    waitStat(8'h20, 8'h00, "R10");
    repeat (4) @(posedge clk);
    rdReg(3'd1, rv); check("R9 idle after read", rv[1], 1'b1);
    wrReg(3'd1, 8'h02);

    // rejected address, global enable off, idle interrupt disabled
    wrReg(3'd0, 8'h60);
    waitStat(8'h20, 8'h20, "R4");
    repeat (4 * QUARTER) @(posedge clk);
    wrReg(3'd5, 8'h00);
    rdReg(3'd5, rv); check("R7 cleared", rv, 8'h00);
    xferByte({7'h11, 1'b0});
    rdReg(3'd1, rv); check("R5 no ack", rv[0], 1'b1);
    check("R8 gated irq", irq, 1'b0);
    wrReg(3'd1, 8'h02);
    wrReg(3'd0, 8'h00);
    waitStat(8'h20, 8'h00, "R10");
    repeat (4) @(posedge clk);
    rdReg(3'd1, rv); check("R9 disabled no flag", rv[1], 1'b0);
    check("R2 one START per transfer", slvStarts - startBase, 3);
    check("R2 one STOP per transfer", slvStops - stopBase, 3);
    check("R2 idle lines", {sclLine, sdaLine}, 2'b11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule